// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit picks out one bit of a 16-bit or 32-bit operand, using a bit offset. It returns the original value of that bit as a carry, and it returns the operand with that bit left alone, inverted, cleared or forced high. The choice depends on a two-bit operation code. A single datapath serves all four operations. A start strobe launches one operation. The carry, the modified word and a byte-address adjustment appear together one cycle later, and a one-cycle done pulse marks them.

The offset can come from a register or from an immediate field. A register offset reaches beyond the current word of a bit string held in memory. For such an offset the unit also returns the byte distance from the effective address to the 32-bit word that holds the chosen bit. The surrounding pipeline performs any memory access and writes the modified word back. An immediate offset always points inside the addressed word, so its adjustment is zero. The unit produces no flag other than the carry.

Top module: `bit_test_modify_unit`

## Requirements
- R1: `carry_o` equals the selected bit of the operand as it was before modification, for every operation code.
- R2: Operation codes: 2'b00 returns the operand unchanged, 2'b01 inverts the selected bit, 2'b10 clears it, 2'b11 sets it. Every other bit of the (size-masked) operand passes through unchanged.
- R3: With `imm_i` = 0 the bit number is `offset_i` modulo 32 when `wide_i` = 1, and `offset_i` modulo 16 when `wide_i` = 0.
- R4: With `imm_i` = 1 only `offset_i[7:0]` is the offset. It is reduced modulo 32 and then modulo the operand size. Bits 31:8 of `offset_i` have no effect on any output.
- R5: With `imm_i` = 0, `addr_adj_o` = 4 × floor(`offset_i` / 32), with the offset taken as unsigned, for both operand sizes.
- R6: With `imm_i` = 1, `addr_adj_o` is zero.
- R7: The outputs take their new values at the first clock edge after the edge that samples `start_i` = 1. `done_o` is high for exactly that one cycle per start. The outputs hold while `start_i` is low.
- R8: With `wide_i` = 0, `result_o[31:16]` is zero and `operand_i[31:16]` has no effect.
- R9: While reset is asserted, all outputs are zero.
- R10: A 16-bit operand of 16'h081F with register offset 16'h0021 selects bit 1 and gives carry 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launches one operation |
| op_i | input | 2 | Operation code (test, invert, clear, set) |
| wide_i | input | 1 | 1 = 32-bit operand, 0 = 16-bit operand |
| imm_i | input | 1 | 1 = offset comes from an 8-bit immediate |
| operand_i | input | 32 | Base operand |
| offset_i | input | 32 | Bit offset |
| result_o | output | 32 | Modified operand |
| carry_o | output | 1 | Selected bit before modification |
| addr_adj_o | output | 32 | Byte adjustment to the effective address |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The hardest cases to reach are the ones where offset bits that should be ignored differ from bits that matter. Examples are an immediate offset whose bits above 7 are set, and a 16-bit operand whose offset and operand both have their upper halves set. A bug in these cases changes only the address adjustment or the upper half of the result, never the carry. The sweep therefore pairs small offsets with offsets whose upper bits are dense, and operands that are all ones, all zeros and mixed. It crosses these with both sizes, both offset sources and all four codes, so that dropped masking shows up in the adjustment or in the upper result bits.

// File: rtl/btm_pkg.sv
package btm_pkg;
  typedef enum logic [1:0] {
    BTM_TEST  = 2'b00,
    BTM_FLIP  = 2'b01,
    BTM_CLEAR = 2'b10,
    BTM_SET   = 2'b11
  } btm_op_e;

  // Value of one bit after the operation; hit marks the selected position.
  function automatic logic btm_apply(btm_op_e op, logic b, logic hit);
    logic r;
    r = b;
    if (hit) begin
      unique case (op)
        BTM_TEST:  r = b;
        BTM_FLIP:  r = ~b;
        BTM_CLEAR: r = 1'b0;
        BTM_SET:   r = 1'b1;
        default:   r = b;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/btm_index_calc.sv
module btm_index_calc #(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 32,
  parameter int ADJ_W  = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [OFS_W-1:0] offset_i,
  input  logic             wide_i,
  input  logic             imm_i,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic [ADJ_W-1:0] adj_o
);
  localparam int BYTE_SH = $clog2(DATA_W / 8);

  logic [OFS_W-1:0] word_num;

  // The low IDX_W bits of an 8-bit immediate equal its value modulo DATA_W,
  // so both offset sources share the same bit selection.
  always_comb begin
    if (wide_i) bit_idx_o = offset_i[IDX_W-1:0];
    else        bit_idx_o = {1'b0, offset_i[IDX_W-2:0]};
  end

  assign word_num = offset_i >> IDX_W;

  always_comb begin
    if (imm_i) adj_o = '0;
    else       adj_o = ADJ_W'(word_num) << BYTE_SH;
  end
endmodule

// File: rtl/btm_bit_modifier.sv
module btm_bit_modifier
  import btm_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic              wide_i,
  input  btm_op_e           op_i,
  output logic [DATA_W-1:0] word_o,
  output logic              carry_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic hit;
    assign hit = (bit_idx_i == IDX_W'(i));
    if (i >= HALF_W) begin : g_upper
      assign word_o[i] = wide_i ? btm_apply(op_i, word_i[i], hit) : 1'b0;
    end else begin : g_lower
      assign word_o[i] = btm_apply(op_i, word_i[i], hit);
    end
  end

  assign carry_o = word_i[bit_idx_i];
endmodule

// File: rtl/bit_test_modify_unit.sv
module bit_test_modify_unit
  import btm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 32,
  parameter int ADJ_W  = 32,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              wide_i,
  input  logic              imm_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [OFS_W-1:0]  offset_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic [ADJ_W-1:0]  addr_adj_o,
  output logic              done_o
);
  logic [IDX_W-1:0]  bit_idx;
  logic [ADJ_W-1:0]  adj_calc;
  logic [DATA_W-1:0] word_calc;
  logic              carry_calc;

  logic [DATA_W-1:0] result_d, result_q;
  logic [ADJ_W-1:0]  adj_d, adj_q;
  logic              carry_d, carry_q;
  logic              done_d, done_q;

  btm_index_calc #(.DATA_W(DATA_W), .OFS_W(OFS_W), .ADJ_W(ADJ_W)) idx_i (
    .offset_i (offset_i),
    .wide_i   (wide_i),
    .imm_i    (imm_i),
    .bit_idx_o(bit_idx),
    .adj_o    (adj_calc)
  );

  btm_bit_modifier #(.DATA_W(DATA_W)) mod_i (
    .word_i   (operand_i),
    .bit_idx_i(bit_idx),
    .wide_i   (wide_i),
    .op_i     (btm_op_e'(op_i)),
    .word_o   (word_calc),
    .carry_o  (carry_calc)
  );

  // Next state: load on start, otherwise hold.
  always_comb begin
    result_d = result_q;
    adj_d    = adj_q;
    carry_d  = carry_q;
    done_d   = start_i;
    if (start_i) begin
      result_d = word_calc;
      adj_d    = adj_calc;
      carry_d  = carry_calc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      adj_q    <= '0;
      carry_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      result_q <= result_d;
      adj_q    <= adj_d;
      carry_q  <= carry_d;
      done_q   <= done_d;
    end
  end

  assign result_o   = result_q;
  assign addr_adj_o = adj_q;
  assign carry_o    = carry_q;
  assign done_o     = done_q;

  p_done_follows_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);
  p_outputs_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(result_o) && $stable(carry_o) && $stable(addr_adj_o)));
  p_upper_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !wide_i) |=> (result_o[DATA_W-1:HALF_W] == '0));
  p_imm_adj_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && imm_i) |=> (addr_adj_o == '0));
  p_adj_aligned_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (addr_adj_o[1:0] == 2'b00));
  p_test_unchanged_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && wide_i && op_i == BTM_TEST) |=> (result_o == $past(operand_i)));
  p_one_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && wide_i) |=> ($countones(result_o ^ $past(operand_i)) <= 1));
  p_set_count_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && wide_i && op_i == BTM_SET) |=>
      ($countones(result_o) == $countones($past(operand_i)) + (carry_o ? 0 : 1)));
  p_clear_count_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && wide_i && op_i == BTM_CLEAR) |=>
      ($countones(result_o) + (carry_o ? 1 : 0) == $countones($past(operand_i))));
endmodule

// File: tb/bit_test_modify_unit_tb_top.sv
`timescale 1ns/1ps
module bit_test_modify_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  op;
  logic        wide;
  logic        imm;
  logic [31:0] operand;
  logic [31:0] offset;
  logic [31:0] result;
  logic        carry;
  logic [31:0] adj;
  logic        done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bit_test_modify_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .wide_i(wide),
    .imm_i(imm), .operand_i(operand), .offset_i(offset), .result_o(result),
    .carry_o(carry), .addr_adj_o(adj), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic run_one(input logic [1:0] o, input bit w, input bit im,
                         input logic [31:0] opd, input logic [31:0] ofs);
    int unsigned size, idx;
    logic [31:0] base, exp_res, exp_adj;
    logic        exp_c;
    size = w ? 32 : 16;
    if (im) idx = ((ofs & 32'hFF) % 32) % size;
    else    idx = ofs % size;
    exp_adj = im ? 32'd0 : (ofs / 32) * 4;
    base    = w ? opd : (opd & 32'h0000_FFFF);
    exp_c   = base[idx];
    case (o)
      2'b00: exp_res = base;
      2'b01: exp_res = base ^ (32'd1 << idx);
      2'b10: exp_res = base & ~(32'd1 << idx);
      default: exp_res = base | (32'd1 << idx);
    endcase
    @(negedge clk);
    start = 1'b1; op = o; wide = w; imm = im; operand = opd; offset = ofs;
    @(negedge clk);
    start = 1'b0;
    chk(carry == exp_c, im ? "R4 R1 carry" : "R3 R1 carry", 32'(carry), 32'(exp_c));
    chk(result == exp_res, "R2 result", result, exp_res);
    chk(adj == exp_adj, im ? "R6 adj" : "R5 adj", adj, exp_adj);
    chk(done == 1'b1, "R7 done", 32'(done), 32'd1);
    if (!w) chk(result[31:16] == 16'h0, "R8 upper", 32'(result[31:16]), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [31:0] pats [4];
    logic [31:0] keep_r;
    pats[0] = 32'h0000_081F; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h0000_0000; pats[3] = 32'hA5C3_3C5A;
    rst_n = 1'b0; start = 1'b0; op = 2'b00; wide = 1'b0; imm = 1'b0;
    operand = '0; offset = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(result == 0 && carry == 0 && adj == 0 && done == 0, "R9 reset",
        result | adj | 32'(carry) | 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: worked example, 16-bit register offset 0x21 selects bit 1
    run_one(2'b00, 1'b0, 1'b0, 32'h0000_081F, 32'h0000_0021);
    chk(carry == 1'b1, "R10 example carry", 32'(carry), 32'd1);

    // R7: outputs hold and done stays low while idle
    run_one(2'b11, 1'b1, 1'b0, 32'h1234_0000, 32'd70);
    keep_r = result;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R7 done low", 32'(done), 32'd0);
    chk(result == keep_r, "R7 hold", result, keep_r);

    // Sweep: codes x sizes x offset source x operands x offsets
    for (int o = 0; o < 4; o++)
      for (int w = 0; w < 2; w++)
        for (int im = 0; im < 2; im++)
          for (int p = 0; p < 4; p++)
            for (int k = 0; k < 80; k++) begin
              logic [31:0] ofs;
              if (k == 79)     ofs = 32'hFFFF_FFFF;
              else if (k < 64) ofs = 32'(k);
              else             ofs = 32'hFFFF_0000 + 32'(k * 1013);
              run_one(2'(o), w[0], im[0], pats[p], ofs);
            end
    finish_run();
  end
endmodule